// File: doc/BRIEF.md
# Microcoded Bus Sampling Sequencer

This block is a small microcoded state machine that captures bytes from an 8-bit parallel bus into a downstream FIFO. It stores four waveform programs. Each program has seven programmable states (0 to 6) and a fixed idle state 7. Each state is one stored instruction, split across four planes: hold or branch control, opcode, output pattern and a flag-logic selector. The host loads the programs through a byte-write port, then fires a start strobe. The engine steps through the selected program until it lands in state 7, or until an abort write halts it.

All configuration shares one 8-bit write data bus, and each register has its own write strobe. A non-decision state holds for a programmed number of cycles. A decision state evaluates a two-input logic function of selected flags and jumps to one of two target states. While idle, the control outputs and the bus drive enable come from two idle registers. While a program runs, they come from the output plane of the current state.

Top module: `wave_seq`

## Requirements
- R1: After reset the engine is idle: `done`=1, `push`=0, `ctl_out`=0, and `bus_oe`=0 because the idle-drive bit resets to 1.
- R2: While idle, `bus_oe` equals the inverse of bit 0 of the idle-drive register (written with `idle_cs_we`). `ctl_out` equals the 6-bit idle control value (written with `idle_ctl_we`, data bits 5:0).
- R3: A `start` pulse while idle, with no abort in the same cycle, launches the program whose index is held in bits 1:0 of the select register (`sel_we`). The launch enters state 0, and `done` is low from the next cycle. Writes to bits 7:2 of the select register have no effect.
- R4: A state whose opcode bit 0 is 0 is a non-decision state. It stays for N cycles, where N is its hold/branch byte, and a value of 0 means 256 cycles. It then moves to the next state number. Leaving state 6 enters idle state 7.
- R5: Opcode bit 1 set makes the state sample: in the first cycle of each visit, `push`=1 and `push_data`=`bus_in`. When `fifo_full` is high the sample is dropped (`push`=0). `push` is never high while idle.
- R6: A state whose opcode bit 0 is 1 is a decision state. It lasts one cycle and then jumps to hold/branch bits 5:3 if the logic result is 1, or to bits 2:0 if it is 0. Reaching state 7 raises `done` in the following cycle.
- R7: The logic byte selects the function with bits 7:6 (00 AND, 01 OR, 10 XOR, 11 A AND NOT B), operand A with bits 5:3 and operand B with bits 2:0. Select codes 0 to 5 read bits 0 to 5 of the current state's output pattern, code 6 reads `fifo_full` and code 7 reads `fifo_empty`.
- R8: When bit 7 of a decision state's hold/branch byte is set, the decision takes two cycles and branches on the result evaluated in the second cycle.
- R9: An `abort_we` pulse forces idle on the next edge. `push` is held low in the abort cycle, and `done` is high from the next cycle.
- R10: While running, `ctl_out` equals bits 5:0 of the current state's output byte, and `bus_oe` equals bit 7 of that byte.
- R11: A `start` pulse while a program runs is ignored.
- R12: Program byte addresses are wave*32 + plane*8 + state. The planes are, in order, hold/branch (0), opcode (1), output (2) and logic (3).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst_n | input | 1 | Synchronous active-low reset |
| prog_we | input | 1 | Program byte write strobe |
| prog_addr | input | 7 | Program byte address |
| wr_data | input | 8 | Shared write data for program and registers |
| sel_we | input | 1 | Select register write strobe |
| idle_cs_we | input | 1 | Idle-drive register write strobe |
| idle_ctl_we | input | 1 | Idle control register write strobe |
| abort_we | input | 1 | Abort register write strobe |
| start | input | 1 | Launch the FIFO-read program |
| bus_in | input | DATA_W | Sampled parallel data bus |
| fifo_full | input | 1 | Downstream FIFO full flag |
| fifo_empty | input | 1 | Downstream FIFO empty flag |
| push | output | 1 | FIFO push strobe |
| push_data | output | DATA_W | Data pushed into the FIFO |
| ctl_out | output | 6 | Control outputs |
| done | output | 1 | High while idle |
| bus_oe | output | 1 | Data bus drive enable |

## Verification
The assertions assume that `fifo_full` is a clean, synchronous level, and that the host writes the program only while the engine is idle. Otherwise the stored instruction can change mid-state. The stimulus loads all program bytes before any launch and never writes the program again during the random phase. The flags, bus data, start and rare abort pulses are randomised freely. Aborts are frequent enough that randomly built looping programs still return to idle.

// File: rtl/wfs_pkg.sv
// Shared constants and types for the waveform sequencer.
// Assumes 8-bit program bytes and a fixed four-plane instruction layout.
package wfs_pkg;
    localparam int WB         = 8;
    localparam int ST_W       = 3;
    localparam int NUM_WAVES  = 4;
    localparam int WAVE_W     = $clog2(NUM_WAVES);
    localparam int NUM_PLANES = 4;
    localparam int PLANE_W    = $clog2(NUM_PLANES);
    localparam int PROG_AW    = WAVE_W + PLANE_W + ST_W;
    localparam int PROG_DEPTH = 1 << PROG_AW;
    localparam int CTL_W      = 6;
    localparam int SRC_W      = CTL_W + 2;
    localparam logic [ST_W-1:0] ST_IDLE = '1;

    typedef enum logic [1:0] {
        LF_AND  = 2'd0,
        LF_OR   = 2'd1,
        LF_XOR  = 2'd2,
        LF_ANDN = 2'd3
    } lfunc_e;

    // plane 0 sits in the low byte
    typedef struct packed {
        logic [WB-1:0] lfn;
        logic [WB-1:0] outb;
        logic [WB-1:0] opc;
        logic [WB-1:0] lenbr;
    } instr_t;
endpackage

// File: rtl/wfs_prog_mem.sv
// Program store: NUM_WAVES waveforms of NUM_PLANES x 8 bytes.
// Writes are byte-wide; the four planes of one state are read in parallel.
// Assumes the host writes only while the engine is idle.
module wfs_prog_mem
    import wfs_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we,
    input  logic [PROG_AW-1:0] waddr,
    input  logic [WB-1:0]      wdata,
    input  logic [WAVE_W-1:0]  rd_wave,
    input  logic [ST_W-1:0]    rd_state,
    output instr_t             instr
);
    logic [WB-1:0] mem [PROG_DEPTH];
    logic [NUM_PLANES-1:0][WB-1:0] planes;

    // store one program byte per write strobe, clear all on reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < PROG_DEPTH; i++) begin
                mem[i] <= '0;
            end
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    // one read port per plane, address = wave | plane | state
    for (genvar p = 0; p < NUM_PLANES; p++) begin : g_plane
        assign planes[p] = mem[{rd_wave, PLANE_W'(p), rd_state}];
    end

    assign instr = instr_t'(planes);
endmodule

// File: rtl/wfs_decide.sv
// Decision evaluator: picks two operands from the flag sources and
// combines them with the function coded in the logic byte.
// Sources 0..5 are the current output pattern, 6 full, 7 empty.
module wfs_decide
    import wfs_pkg::*;
(
    input  logic [WB-1:0]    lfn,
    input  logic [CTL_W-1:0] ctl_pat,
    input  logic             fifo_full,
    input  logic             fifo_empty,
    output logic             result
);
    logic [SRC_W-1:0] src;
    logic             op_a;
    logic             op_b;
    lfunc_e           fsel;

    assign src  = {fifo_empty, fifo_full, ctl_pat};
    assign op_a = src[lfn[5:3]];
    assign op_b = src[lfn[2:0]];
    assign fsel = lfunc_e'(lfn[7:6]);

    // combine the two operands
    always_comb begin
        unique case (fsel)
            LF_AND:  result = op_a & op_b;
            LF_OR:   result = op_a | op_b;
            LF_XOR:  result = op_a ^ op_b;
            LF_ANDN: result = op_a & ~op_b;
            default: result = 1'b0;
        endcase
    end
endmodule

// File: rtl/wfs_engine.sv
// Sequencing core: current state, hold counter and active wave index.
// Non-decision states hold for the programmed count (0 = 256), decision
// states branch on the evaluator result, optionally after a second look.
// Abort has priority over everything; start is honoured only in idle.
module wfs_engine
    import wfs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              abort_i,
    input  logic              fifo_full_i,
    input  logic              decide_i,
    input  logic [WAVE_W-1:0] launch_wave_i,
    input  logic [WB-1:0]     lenbr_i,
    input  logic [WB-1:0]     opc_i,
    output logic [ST_W-1:0]   state_o,
    output logic [WAVE_W-1:0] wave_o,
    output logic              idle_o,
    output logic              push_o
);
    logic [ST_W-1:0]   st_q, st_d;
    logic [WAVE_W-1:0] wave_q, wave_d;
    logic [WB-1:0]     cnt_q, cnt_d;
    logic              idle;
    logic              is_dp;
    logic              samp;
    logic              first;
    logic              hold_last;
    logic              reexec_wait;
    logic              unused_bits;

    assign idle        = (st_q == ST_IDLE);
    assign is_dp       = opc_i[0];
    assign samp        = opc_i[1];
    assign first       = (cnt_q == '0);
    assign hold_last   = (WB'(cnt_q + WB'(1)) == lenbr_i);
    assign reexec_wait = lenbr_i[7] & first;
    assign unused_bits = ^{opc_i[WB-1:2], lenbr_i[6]};

    // next-state selection
    always_comb begin
        st_d   = st_q;
        cnt_d  = cnt_q;
        wave_d = wave_q;
        if (abort_i) begin
            st_d  = ST_IDLE;
            cnt_d = '0;
        end else if (idle) begin
            if (start_i) begin
                st_d   = '0;
                cnt_d  = '0;
                wave_d = launch_wave_i;
            end
        end else if (is_dp) begin
            if (reexec_wait) begin
                cnt_d = WB'(1);
            end else begin
                st_d  = decide_i ? lenbr_i[5:3] : lenbr_i[2:0];
                cnt_d = '0;
            end
        end else if (hold_last) begin
            st_d  = st_q + ST_W'(1);
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + WB'(1);
        end
    end

    // state registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            cnt_q  <= '0;
            wave_q <= '0;
        end else begin
            st_q   <= st_d;
            cnt_q  <= cnt_d;
            wave_q <= wave_d;
        end
    end

    assign state_o = st_q;
    assign wave_o  = wave_q;
    assign idle_o  = idle;
    assign push_o  = ~idle & ~abort_i & samp & first & ~fifo_full_i;
endmodule

// File: rtl/wave_seq.sv
// Top of the waveform sequencer: configuration registers, program
// store, decision evaluator and sequencing core, plus output muxing
// between the idle registers and the running state's output byte.
// Assumes all control inputs are synchronous to clk.
module wave_seq
    import wfs_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               prog_we,
    input  logic [PROG_AW-1:0] prog_addr,
    input  logic [WB-1:0]      wr_data,
    input  logic               sel_we,
    input  logic               idle_cs_we,
    input  logic               idle_ctl_we,
    input  logic               abort_we,
    input  logic               start,
    input  logic [DATA_W-1:0]  bus_in,
    input  logic               fifo_full,
    input  logic               fifo_empty,
    output logic               push,
    output logic [DATA_W-1:0]  push_data,
    output logic [CTL_W-1:0]   ctl_out,
    output logic               done,
    output logic               bus_oe
);
    logic [WAVE_W-1:0] sel_rd_q;
    logic              idle_drv_q;
    logic [CTL_W-1:0]  idle_ctl_q;
    instr_t            instr;
    logic [ST_W-1:0]   cur_state;
    logic [WAVE_W-1:0] cur_wave;
    logic              idle;
    logic              decide;
    logic              unused_bits;

    // configuration registers; only the FIFO-read field of the select byte is kept
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_rd_q   <= '0;
            idle_drv_q <= 1'b1;
            idle_ctl_q <= '0;
        end else begin
            if (sel_we)      sel_rd_q   <= wr_data[WAVE_W-1:0];
            if (idle_cs_we)  idle_drv_q <= wr_data[0];
            if (idle_ctl_we) idle_ctl_q <= wr_data[CTL_W-1:0];
        end
    end

    wfs_prog_mem u_mem (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (prog_we),
        .waddr    (prog_addr),
        .wdata    (wr_data),
        .rd_wave  (cur_wave),
        .rd_state (cur_state),
        .instr    (instr)
    );

    wfs_decide u_dec (
        .lfn        (instr.lfn),
        .ctl_pat    (instr.outb[CTL_W-1:0]),
        .fifo_full  (fifo_full),
        .fifo_empty (fifo_empty),
        .result     (decide)
    );

    wfs_engine u_eng (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_i       (start),
        .abort_i       (abort_we),
        .fifo_full_i   (fifo_full),
        .decide_i      (decide),
        .launch_wave_i (sel_rd_q),
        .lenbr_i       (instr.lenbr),
        .opc_i         (instr.opc),
        .state_o       (cur_state),
        .wave_o        (cur_wave),
        .idle_o        (idle),
        .push_o        (push)
    );

    assign unused_bits = instr.outb[6];

    // output muxing between idle registers and the running state
    always_comb begin
        if (idle) begin
            ctl_out = idle_ctl_q;
            bus_oe  = ~idle_drv_q;
        end else begin
            ctl_out = instr.outb[CTL_W-1:0];
            bus_oe  = instr.outb[7];
        end
    end

    assign push_data = bus_in;
    assign done      = idle;
endmodule

// File: rtl/wave_seq_chk.sv
// Port-level temporal checks for the waveform sequencer, bound to the top.
module wave_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       abort_we,
    input logic       start,
    input logic       fifo_full,
    input logic       push,
    input logic       done,
    input logic [5:0] ctl_out,
    input logic [5:0] idle_ctl
);
    AST_ABORT_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        abort_we |=> done); // R9
    AST_NO_PUSH_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_full |-> !push); // R5
    AST_START_LAUNCHES: assert property (@(posedge clk) disable iff (!rst_n)
        (done && start && !abort_we) |=> !done); // R3
    AST_IDLE_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done); // R3
    AST_IDLE_CTL: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (ctl_out == idle_ctl)); // R2
endmodule

bind wave_seq wave_seq_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .abort_we  (abort_we),
    .start     (start),
    .fifo_full (fifo_full),
    .push      (push),
    .done      (done),
    .ctl_out   (ctl_out),
    .idle_ctl  (idle_ctl_q)
);

// File: tb/wave_seq_tb.sv
module wave_seq_tb;
    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic       rst_n;
    logic       prog_we, sel_we, idle_cs_we, idle_ctl_we, abort_we, start;
    logic [6:0] prog_addr;
    logic [7:0] wr_data, bus_in, push_data;
    logic       fifo_full, fifo_empty;
    logic       push, done, bus_oe;
    logic [5:0] ctl_out;

    wave_seq u_dut (
        .clk(clk), .rst_n(rst_n), .prog_we(prog_we), .prog_addr(prog_addr),
        .wr_data(wr_data), .sel_we(sel_we), .idle_cs_we(idle_cs_we),
        .idle_ctl_we(idle_ctl_we), .abort_we(abort_we), .start(start),
        .bus_in(bus_in), .fifo_full(fifo_full), .fifo_empty(fifo_empty),
        .push(push), .push_data(push_data), .ctl_out(ctl_out),
        .done(done), .bus_oe(bus_oe)
    );

    int n_cmp = 0;
    int n_bad = 0;
    int pushes = 0;

    // reference model state
    logic [7:0] m_mem [128];
    logic [2:0] m_st;
    logic [1:0] m_wave, m_sel;
    logic [7:0] m_cnt;
    logic       m_drv;
    logic [5:0] m_ictl;
    logic       s_done, s_oe;
    logic [5:0] s_ctl;

    task automatic chk(string req, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [6:0] paddr(int w, int p, int s);
        return 7'(w * 32 + p * 8 + s);
    endfunction

    function automatic logic m_eval(logic [7:0] lf, logic [5:0] ob, logic f, logic e);
        logic [7:0] src;
        logic a, b;
        src = {e, f, ob};
        a = src[lf[5:3]];
        b = src[lf[2:0]];
        case (lf[7:6])
            2'd0: return a & b;
            2'd1: return a | b;
            2'd2: return a ^ b;
            default: return a & ~b;
        endcase
    endfunction

    // one clock: compare against model, advance model, clear strobes
    task automatic step();
        logic idle, ep;
        logic [7:0] lb, op, ob, lf, ncnt;
        logic [2:0] nst;
        logic [1:0] nw;
        int base;
        #3;
        idle = (m_st == 3'd7);
        base = int'(m_wave) * 32 + int'(m_st);
        lb = m_mem[base]; op = m_mem[base + 8]; ob = m_mem[base + 16]; lf = m_mem[base + 24];
        ep = !idle && !abort_we && op[1] && (m_cnt == 8'd0) && !fifo_full;
        chk("R5 push", int'(push), int'(ep));
        if (ep) chk("R5 push_data", int'(push_data), int'(bus_in));
        if (idle) begin
            chk("R2 ctl_out", int'(ctl_out), int'(m_ictl));
            chk("R2 bus_oe", int'(bus_oe), int'(!m_drv));
        end else begin
            chk("R10 ctl_out", int'(ctl_out), int'(ob[5:0]));
            chk("R10 bus_oe", int'(bus_oe), int'(ob[7]));
        end
        chk("R6 done", int'(done), int'(idle));
        s_done = done; s_ctl = ctl_out; s_oe = bus_oe;
        if (push) pushes++;
        nst = m_st; ncnt = m_cnt; nw = m_wave;
        if (abort_we) begin
            nst = 3'd7; ncnt = 8'd0;
        end else if (idle) begin
            if (start) begin nst = 3'd0; ncnt = 8'd0; nw = m_sel; end
        end else if (op[0]) begin
            if (lb[7] && m_cnt == 8'd0) ncnt = 8'd1;
            else begin
                nst = m_eval(lf, ob[5:0], fifo_full, fifo_empty) ? lb[5:3] : lb[2:0];
                ncnt = 8'd0;
            end
        end else if (8'(m_cnt + 8'd1) == lb) begin
            nst = m_st + 3'd1; ncnt = 8'd0;
        end else begin
            ncnt = m_cnt + 8'd1;
        end
        @(posedge clk);
        #1;
        m_st = nst; m_cnt = ncnt; m_wave = nw;
        if (prog_we) m_mem[prog_addr] = wr_data;
        if (sel_we) m_sel = wr_data[1:0];
        if (idle_cs_we) m_drv = wr_data[0];
        if (idle_ctl_we) m_ictl = wr_data[5:0];
        prog_we = 0; sel_we = 0; idle_cs_we = 0; idle_ctl_we = 0; abort_we = 0; start = 0;
    endtask

    task automatic wr_prog(int w, int p, int s, logic [7:0] v);
        prog_we = 1; prog_addr = paddr(w, p, s); wr_data = v;
        step();
    endtask

    task automatic wr_sel(logic [7:0] v);
        sel_we = 1; wr_data = v;
        step();
    endtask

    // run a decision program on wave 1 and check the branch target
    task automatic dp_run(logic f, logic e, int exp_ctl, string tag);
        fifo_full = f; fifo_empty = e; start = 1;
        step();
        step();
        step();
        chk(tag, int'(s_ctl), exp_ctl);
        step();
        chk("R6 done after branch to 7", int'(s_done), 1);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int n;
        void'($urandom(32'h5eed));
        rst_n = 0; prog_we = 0; sel_we = 0; idle_cs_we = 0; idle_ctl_we = 0;
        abort_we = 0; start = 0; prog_addr = 0; wr_data = 0; bus_in = 0;
        fifo_full = 0; fifo_empty = 0;
        for (int i = 0; i < 128; i++) m_mem[i] = 8'h00;
        m_st = 3'd7; m_cnt = 0; m_wave = 0; m_sel = 0; m_drv = 1; m_ictl = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        #3;
        // R1 reset state
        chk("R1 done", int'(done), 1);
        chk("R1 push", int'(push), 0);
        chk("R1 ctl_out", int'(ctl_out), 0);
        chk("R1 bus_oe", int'(bus_oe), 0);
        @(posedge clk); #1;

        // R2 idle outputs
        idle_ctl_we = 1; wr_data = 8'h2a; step();
        idle_cs_we = 1; wr_data = 8'h00; step();
        step();
        chk("R2 idle ctl value", int'(s_ctl), 8'h2a);
        chk("R2 idle drive off", int'(s_oe), 1);
        idle_cs_we = 1; wr_data = 8'h01; step();

        // wave 2: S0 sample hold 3, S1 hold 256, S2..S6 hold 1 (R12 layout)
        wr_prog(2, 0, 0, 8'd3);  wr_prog(2, 1, 0, 8'h02); wr_prog(2, 2, 0, 8'h85);
        wr_prog(2, 0, 1, 8'd0);  wr_prog(2, 2, 1, 8'h01);
        for (int s = 2; s < 7; s++) wr_prog(2, 0, s, 8'd1);
        wr_sel(8'hfe);  // bits 1:0 = 2, upper bits ignored (R3)
        fifo_full = 0; bus_in = 8'h5a; start = 1;
        step();
        pushes = 0;
        step();
        chk("R12 ctl_out wave2 S0", int'(s_ctl), 5);
        chk("R12 bus_oe wave2 S0", int'(s_oe), 1);
        chk("R3 done low after start", int'(s_done), 0);
        n = 1;
        for (int i = 0; i < 400 && !s_done; i++) begin
            if (i == 5) begin start = 1; sel_we = 1; wr_data = 8'h01; end
            bus_in = 8'(i);
            step();
            if (!s_done) n++;
        end
        chk("R4 hold cycles incl 256", n, 264);
        chk("R11 start ignored while running", n, 264);
        chk("R5 one sample per visit", pushes, 1);

        // wave 1 decisions: S0 DP (1->5, 0->3), S3/S5 DP to idle
        wr_prog(1, 0, 0, 8'h2b); wr_prog(1, 1, 0, 8'h01); wr_prog(1, 3, 0, 8'hb7);
        wr_prog(1, 0, 3, 8'h3f); wr_prog(1, 1, 3, 8'h01); wr_prog(1, 2, 3, 8'h03);
        wr_prog(1, 0, 5, 8'h3f); wr_prog(1, 1, 5, 8'h01); wr_prog(1, 2, 5, 8'h05);
        wr_sel(8'h01);
        dp_run(1, 0, 5, "R7 xor full^empty=1");
        dp_run(0, 0, 3, "R7 xor full^empty=0");
        dp_run(1, 1, 3, "R7 xor both set");
        wr_prog(1, 3, 0, 8'hf7);
        dp_run(1, 0, 5, "R7 andnot full&~empty");
        dp_run(1, 1, 3, "R7 andnot empty set");
        wr_prog(1, 3, 0, 8'h77);  // OR of full, empty
        dp_run(0, 1, 5, "R7 or via empty");

        // R8 re-execute: first look full=1, second look full=0 -> S3
        wr_prog(1, 3, 0, 8'hb7); wr_prog(1, 0, 0, 8'hab);
        fifo_full = 1; fifo_empty = 0; start = 1;
        step();
        step();
        fifo_full = 0;
        step();
        step();
        chk("R8 branch on second evaluation", int'(s_ctl), 3);
        step();
        chk("R8 done after two-cycle decision", int'(s_done), 1);

        // R9 abort in a sampling cycle
        wr_sel(8'h02);
        fifo_full = 0; start = 1;
        step();
        abort_we = 1; pushes = 0;
        step();
        chk("R9 push suppressed on abort", pushes, 0);
        step();
        chk("R9 idle after abort", int'(s_done), 1);

        // R5 full drops sample
        fifo_full = 1; start = 1; step();
        pushes = 0; step();
        chk("R5 sample dropped when full", pushes, 0);
        abort_we = 1; step();

        // random programs and stimulus
        for (int a = 0; a < 128; a++) begin
            prog_we = 1; prog_addr = 7'(a); wr_data = 8'($urandom);
            if (a % 32 < 8) wr_data = {wr_data[7:6] & 2'b10, wr_data[5:0]} | 8'h01;
            step();
        end
        for (int c = 0; c < 6000; c++) begin
            start      = ($urandom % 6) == 0;
            abort_we   = ($urandom % 40) == 0;
            fifo_full  = ($urandom % 3) == 0;
            fifo_empty = ($urandom % 3) == 0;
            bus_in     = 8'($urandom);
            if (($urandom % 97) == 0) begin sel_we = 1; wr_data = 8'($urandom); end
            else if (($urandom % 89) == 0) begin idle_ctl_we = 1; wr_data = 8'($urandom); end
            else if (($urandom % 83) == 0) begin idle_cs_we = 1; wr_data = 8'($urandom); end
            step();
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule